// File: doc/BRIEF.md
# Edge-Latched Interrupt Aggregator

This block gathers six active-high peripheral request lines into one sticky pending flag for an 8-bit host that has a single active-low interrupt input. A request is registered when one of the lines goes from low to high; a line that simply stays high does not raise the flag again. Each line passes through a two-flop synchroniser before the rising-edge detector, so the lines may be asynchronous to the host clock.

The host clears the pending flag without a separate acknowledge register. Any read that it makes through the peripheral I/O window or the peripheral memory window clears the flag as a side effect. The host can also poll the flag: while its status register is being read, the block drives the flag onto one bit of the device data bus. The output enable for that bit is active only during the read.

The block also has an indicator output that follows the flag. A prioritised readout reports the number of the highest-priority request line that is currently high. Lines are numbered 2 to 7, and line 2 has the highest priority.

Top module: `irq_merge_top`

## Requirements
- R1: `req_i` bit k carries request line k+2. A low-to-high change on any bit sets the pending flag. If the line changes between two clock edges, the flag is visible after the third rising clock edge that follows the change.
- R2: A request line that is held high after the flag has been cleared does not set the flag again. Only a new low-to-high change sets it.
- R3: `irq_n_o` is low exactly when the flag is set, and `ind_o` is high exactly when the flag is set.
- R4: When `io_rd_i` is high at a clock edge and no new request edge arrives at that edge, the flag is clear after that edge.
- R5: When `mem_rd_i` is high at a clock edge and no new request edge arrives at that edge, the flag is clear after that edge.
- R6: When a clear strobe and a new request edge meet at the same clock edge, the new request edge wins and the flag stays set.
- R7: `stat_bit_oe_o` equals `stat_rd_i`. `stat_bit_o` carries the flag while `stat_rd_i` is high and is 0 otherwise.
- R8: While `rst_n` is low, the flag is clear, `irq_n_o` is 1 and `prio_vld_o` is 0. Reset also clears the edge history, so a line that is high when reset is released counts as a new request.
- R9: `prio_vld_o` is 1 when any synchronised line is high. `prio_num_o` then gives the line number (2 to 7) of the lowest-indexed high bit, and it is 0 when `prio_vld_o` is 0. A line change shows on these outputs after the second clock edge.
- R10: A status read (`stat_rd_i`) without a window read leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Request lines; bit 0 is line 2, bit 5 is line 7 |
| io_rd_i | input | 1 | Read strobe for the peripheral I/O window |
| mem_rd_i | input | 1 | Read strobe for the peripheral memory window |
| stat_rd_i | input | 1 | Status register read strobe |
| irq_n_o | output | 1 | Active-low host interrupt |
| stat_bit_o | output | 1 | Flag value for the status data bit |
| stat_bit_oe_o | output | 1 | Output enable for the status data bit |
| ind_o | output | 1 | Indicator, high while the flag is set |
| prio_num_o | output | 3 | Number of the highest-priority high line |
| prio_vld_o | output | 1 | Priority readout valid |

## Verification
A corrupted synchroniser or edge-history register shows up as a flag that rises one cycle early or late, or as a flag that rises again while a line is simply held high after a clear. A behavioural model compares both faults against the ports every cycle, so they are seen within two or three clocks of the line change. A wrong clear or a wrong tie-break between clear and set shows on `irq_n_o` and `ind_o` in the cycle after the read strobe. The window-read/new-edge collision is forced on purpose by a directed sequence.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Default geometry of the aggregator
  localparam int unsigned REQ_LINES   = 6;
  localparam int unsigned FIRST_ID    = 2;
  localparam int unsigned SYNC_DEPTH  = 2;

  // Width needed to carry the largest line number
  function automatic int unsigned id_width(input int unsigned lines, input int unsigned base);
    return $clog2(lines + base);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = async_i;
    for (int s = 1; s < int'(STAGES); s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  generate
    for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[g] <= '0;
        end else begin
          stg_q[g] <= stg_d[g];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= lvl_i;
    end
  end

  assign rise_o = lvl_i & ~hist_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned WIDTH = 6,
  parameter int unsigned BASE  = 2,
  parameter int unsigned NUM_W = 3
) (
  input  logic [WIDTH-1:0] lvl_i,
  output logic [NUM_W-1:0] num_o,
  output logic             vld_o
);

  // Walk from the lowest-priority line upward so the lowest index wins
  always_comb begin
    num_o = '0;
    vld_o = 1'b0;
    for (int i = int'(WIDTH) - 1; i >= 0; i--) begin
      if (lvl_i[i]) begin
        vld_o = 1'b1;
        num_o = NUM_W'(int'(BASE) + i);
      end
    end
  end

endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top #(
  parameter int unsigned NUM_REQ     = irq_agg_pkg::REQ_LINES,
  parameter int unsigned BASE_ID     = irq_agg_pkg::FIRST_ID,
  parameter int unsigned SYNC_STAGES = irq_agg_pkg::SYNC_DEPTH,
  parameter int unsigned NUM_W       = irq_agg_pkg::id_width(NUM_REQ, BASE_ID)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               io_rd_i,
  input  logic               mem_rd_i,
  input  logic               stat_rd_i,
  output logic               irq_n_o,
  output logic               stat_bit_o,
  output logic               stat_bit_oe_o,
  output logic               ind_o,
  output logic [NUM_W-1:0]   prio_num_o,
  output logic               prio_vld_o
);

  logic [NUM_REQ-1:0] lvl_sync;
  logic [NUM_REQ-1:0] rise;
  logic               any_rise;
  logic               rd_clr;
  logic               flag_q;
  logic               flag_d;
  logic               flag_en;

  irq_sync #(
    .WIDTH  (NUM_REQ),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (req_i),
    .sync_o  (lvl_sync)
  );

  irq_edge_det #(
    .WIDTH (NUM_REQ)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_sync),
    .rise_o (rise)
  );

  irq_prio_enc #(
    .WIDTH (NUM_REQ),
    .BASE  (BASE_ID),
    .NUM_W (NUM_W)
  ) u_prio (
    .lvl_i (lvl_sync),
    .num_o (prio_num_o),
    .vld_o (prio_vld_o)
  );

  // Next state of the pending flag: a new edge outranks a clearing read
  assign any_rise = |rise;
  assign rd_clr   = io_rd_i | mem_rd_i;
  assign flag_en  = any_rise | rd_clr;

  always_comb begin
    flag_d = flag_q;
    if (any_rise) begin
      flag_d = 1'b1;
    end else if (rd_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign irq_n_o       = ~flag_q;
  assign ind_o         = flag_q;
  assign stat_bit_oe_o = stat_rd_i;
  assign stat_bit_o    = stat_rd_i & flag_q;

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    any_rise |=> flag_q); // R1

  AST_LEVEL_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !any_rise) |=> !flag_q); // R2

  AST_IRQ_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o != ind_o); // R3

  AST_IO_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_i && !any_rise) |=> !ind_o); // R4

  AST_MEM_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_i && !any_rise) |=> !ind_o); // R5

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && any_rise) |=> !irq_n_o); // R6

  AST_OE_GATES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_bit_oe_o |-> !stat_bit_o); // R7

  AST_PRIO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    prio_vld_o |-> (prio_num_o >= NUM_W'(BASE_ID))); // R9

  AST_STATUS_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !rd_clr && !any_rise) |=> $stable(ind_o)); // R10

endmodule

// File: tb/tb_irq_merge_top.sv
`timescale 1ns/1ps
module tb_irq_merge_top;

  logic       clk;
  logic       rst_n;
  logic [5:0] req_i;
  logic       io_rd_i, mem_rd_i, stat_rd_i;
  logic       irq_n_o, stat_bit_o, stat_bit_oe_o, ind_o, prio_vld_o;
  logic [2:0] prio_num_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  irq_merge_top dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .io_rd_i       (io_rd_i),
    .mem_rd_i      (mem_rd_i),
    .stat_rd_i     (stat_rd_i),
    .irq_n_o       (irq_n_o),
    .stat_bit_o    (stat_bit_o),
    .stat_bit_oe_o (stat_bit_oe_o),
    .ind_o         (ind_o),
    .prio_num_o    (prio_num_o),
    .prio_vld_o    (prio_vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: history of input samples, newest at the front
  logic [5:0] hist [$];
  bit         m_flag;

  task automatic model_clear();
    hist.delete();
    for (int i = 0; i < 3; i++) hist.push_back(6'h00);
    m_flag = 1'b0;
  endtask

  function automatic int exp_num(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return i + 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      model_clear();
    end else begin
      if ((hist[1] & ~hist[2]) != 6'h00) m_flag = 1'b1;
      else if (io_rd_i || mem_rd_i)      m_flag = 1'b0;
      hist.push_front(req_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Every-cycle comparison, sampled 1 ns after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      chk("R3 irq_n", irq_n_o, !m_flag);
      chk("R3 ind", ind_o, m_flag);
      chk("R7 oe", stat_bit_oe_o, stat_rd_i);
      chk("R7 bit", stat_bit_o, stat_rd_i & m_flag);
      chk("R9 vld", prio_vld_o, hist[1] != 6'h00);
      chk("R9 num", prio_num_o, exp_num(hist[1]));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles >= 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
    finish_run();
  end

  initial begin
    model_clear();
    rst_n = 1'b0; req_i = '0; io_rd_i = 0; mem_rd_i = 0; stat_rd_i = 0;
    step(3);
    #1;
    chk("R8 reset irq_n", irq_n_o, 1);
    chk("R8 reset vld", prio_vld_o, 0);
    @(negedge clk); rst_n = 1'b1;
    step(2);

    // R1: line 2 rises, flag appears after third edge
    req_i[0] = 1'b1;
    step(2); #1;
    chk("R1 not yet", irq_n_o, 1);
    chk("R9 line2 num", prio_num_o, 2);
    step(1); #1;
    chk("R1 set", irq_n_o, 0);

    // R7/R10: status read shows flag, keeps it
    @(negedge clk); stat_rd_i = 1; #1;
    chk("R7 bit on read", stat_bit_o, 1);
    chk("R7 oe on read", stat_bit_oe_o, 1);
    @(negedge clk); stat_rd_i = 0; #1;
    chk("R10 flag kept", ind_o, 1);
    chk("R7 bit idle", stat_bit_o, 0);

    // R4: io read clears; R2: held level does not re-set
    @(negedge clk); io_rd_i = 1;
    @(negedge clk); io_rd_i = 0; #1;
    chk("R4 io clear", ind_o, 0);
    step(5); #1;
    chk("R2 level held", ind_o, 0);

    // R9 priority with several lines, R1 on line 5
    req_i[3] = 1'b1; req_i[5] = 1'b1;
    step(3); #1;
    chk("R1 second line", ind_o, 1);
    chk("R9 line2 wins", prio_num_o, 2);
    req_i[0] = 1'b0;
    step(2); #1;
    chk("R9 line5 wins", prio_num_o, 5);

    // R5: memory read clears
    @(negedge clk); mem_rd_i = 1;
    @(negedge clk); mem_rd_i = 0; #1;
    chk("R5 mem clear", ind_o, 0);

    // R6: clear and new edge at the same clock edge
    req_i = '0;
    step(4);
    req_i[1] = 1'b1;
    step(2);
    mem_rd_i = 1;
    @(negedge clk); mem_rd_i = 0; #1;
    chk("R6 edge wins", ind_o, 1);
    @(negedge clk); io_rd_i = 1;
    @(negedge clk); io_rd_i = 0; #1;
    chk("R4 clear after collision", ind_o, 0);
    stat_rd_i = 1; #1;
    chk("R7 bit clear flag", stat_bit_o, 0);
    @(negedge clk); stat_rd_i = 0;

    // R8: reset with line high, release counts as new edge
    rst_n = 1'b0; #1;
    chk("R8 async clear", irq_n_o, 1);
    chk("R8 vld cleared", prio_vld_o, 0);
    step(2); rst_n = 1'b1;
    step(3); #1;
    chk("R8 edge after release", ind_o, 1);

    // Random phase against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) req_i[$urandom_range(0, 5)] ^= 1'b1;
      io_rd_i   = ($urandom_range(0, 9) == 0);
      mem_rd_i  = ($urandom_range(0, 11) == 0);
      stat_rd_i = ($urandom_range(0, 3) == 0);
    end
    step(2);
    finish_run();
  end

endmodule